// File: doc/BRIEF.md
# Reset Sequencing Controller

This controller runs in the slow clock domain. It decides when the processor core, the peripherals and the board-level reset line are held in reset. It watches two things:

- a sample of the shared open-drain reset pin (`pin_n_i`), which is low whenever any driver, including this block, pulls the line down;
- an active-high brownout flag (`bod_i`).

Both inputs pass through two-flop synchronizers before the state machine acts on them.

The state machine has five states:

- `ST_IDLE`: no reset in progress.
- `ST_BROWN`: a brownout is present.
- `ST_EXT`: the block is pulling the pin for its timed pulse.
- `ST_HOLD`: the pulse has ended and the block waits until the pin is seen high.
- `ST_START`: the startup countdown before the processor is released.

The transitions are:

- `IDLE->EXT` when a low pin is seen that this block did not cause.
- `EXT->HOLD` on the last cycle of the pulse timer.
- `HOLD->START` once the synchronized pin reads high.
- `BROWN->START` once the synchronized brownout flag falls.
- `START->IDLE` after three startup cycles.
- `any->BROWN` whenever the synchronized brownout flag is high. This transition has priority over all others.

The length of the block's own pulse on the pin is 2^(L+1) slow-clock cycles, where L is the `ext_len_i` field. The pulse follows both a user reset and a brownout. In the brownout case it starts when the flag falls and runs alongside the startup countdown. When the processor reset is released, the cause of that reset is latched into `cause_o` and held until the next release.

Top module: `rstseq_ctrl`

## Requirements
- R1: After `rst_n` is released, `proc_rst_n_o`, `periph_rst_n_o` and `pin_drive_n_o` are all 1 and `cause_o` is 0.
- R2: A low on `pin_n_i` driven before clock edge k, with the block idle, makes `proc_rst_n_o` go low right after edge k+2.
- R3: In a user reset, `pin_drive_n_o` is 0 for exactly 2^(`ext_len_i`+1) consecutive cycles, starting at the same edge as the processor reset.
- R4: If an outside driver holds `pin_n_i` low for H cycles, the processor reset stays low for max(N+6, H+3) cycles, where N = 2^(`ext_len_i`+1).
- R5: The processor reset rises exactly three cycles after the state machine has seen the end of the reset condition. That end is either a synchronized pin high or a synchronized brownout flag low. The rise therefore comes right after edge p+5 for a pin released before edge p, and right after edge c+5 for a brownout flag dropped before edge c.
- R6: A brownout flag that is high before edge b drives all three reset outputs low right after edge b+2.
- R7: A brownout that lasts D cycles, starting from idle, holds the processor reset low for D+3 cycles.
- R8: A brownout that lasts D cycles holds `pin_drive_n_o` low for D+N consecutive cycles.
- R9: `cause_o` changes only on the rising edge of `proc_rst_n_o`. It takes the value 4 (3'b100) after a user reset and 5 (3'b101) after a brownout.
- R10: A brownout that arrives during a user reset's pulse aborts that sequence. The sequence then ends as a brownout, with cause 5 and a processor reset lasting j+D+3 cycles, where j is the brownout's start offset from the user reset.
- R11: `periph_rst_n_o` equals `proc_rst_n_o` in every cycle.
- R12: A low on `pin_n_i` caused by the block's own drive, including the two synchronizer cycles after the drive ends, never starts a new user reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous reset of the controller itself, active low |
| pin_n_i | input | 1 | Sampled level of the shared reset pin, low while the pin is pulled |
| bod_i | input | 1 | Brownout flag, active high, asynchronous |
| ext_len_i | input | LEN_W (4) | Pulse length code L; the pulse lasts 2^(L+1) cycles |
| proc_rst_n_o | output | 1 | Processor reset, active low |
| periph_rst_n_o | output | 1 | Peripheral reset, active low |
| pin_drive_n_o | output | 1 | Pulls the reset pin when 0 |
| cause_o | output | 3 | Cause of the last reset: 0 none, 4 user, 5 brownout |

## Verification
A brownout can arrive in the same cycle as a live user-reset pulse. The bench provokes this by raising `bod_i` a random 1 to N cycles after pulling the pin. It then judges the total low time of the processor reset and of the pin drive against j+D+3 and j+D+N, and checks that the final cause is 5. The other overlap comes after a brownout: the pin pulse keeps running while the startup count finishes and the machine returns to `ST_IDLE`. The bench loops the drive back onto the pin input and counts any low on the processor reset after its first release, which must be zero.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int CAUSE_W = 3;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 3'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_USER  = 3'd4;
    localparam logic [CAUSE_W-1:0] CAUSE_BROWN = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BROWN = 3'd1,
        ST_EXT   = 3'd2,
        ST_HOLD  = 3'd3,
        ST_START = 3'd4
    } rs_state_e;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_len_timer.sv
module rstseq_len_timer #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             active_o,
    output logic             last_o
);

    localparam int CNT_W = (1 << LEN_W) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [LEN_W:0]   shift_amt;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        shift_amt = {1'b0, len_i} + {{LEN_W{1'b0}}, 1'b1};
        load_val  = {{(CNT_W-1){1'b0}}, 1'b1} << shift_amt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (clear_i)       cnt_q <= '0;
        else if (load_i)        cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign active_o = (cnt_q != '0);
    assign last_o   = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int START_CYC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bod_s_i,
    input  logic               pin_s_i,
    input  logic               own_echo_i,
    input  logic               tmr_last_i,
    output logic               tmr_load_o,
    output logic               tmr_clear_o,
    output logic               core_hold_o,
    output logic               brown_hold_o,
    output logic [CAUSE_W-1:0] cause_o
);

    localparam int STC_W = (START_CYC > 1) ? $clog2(START_CYC) : 1;
    localparam logic [STC_W-1:0] STC_LAST = STC_W'(START_CYC - 1);

    rs_state_e          state_q, state_d;
    logic [STC_W-1:0]   stc_q;
    logic [CAUSE_W-1:0] pend_q, pend_d;
    logic [CAUSE_W-1:0] cause_q;
    logic               release_w;

    // next state and timer control
    always_comb begin
        state_d     = state_q;
        pend_d      = pend_q;
        tmr_load_o  = 1'b0;
        tmr_clear_o = 1'b0;
        release_w   = 1'b0;
        if (bod_s_i) begin
            state_d     = ST_BROWN;
            pend_d      = CAUSE_BROWN;
            tmr_clear_o = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!pin_s_i && !own_echo_i) begin
                        state_d    = ST_EXT;
                        pend_d     = CAUSE_USER;
                        tmr_load_o = 1'b1;
                    end
                end
                ST_BROWN: begin
                    state_d    = ST_START;
                    tmr_load_o = 1'b1;
                end
                ST_EXT: begin
                    if (tmr_last_i) state_d = ST_HOLD;
                end
                ST_HOLD: begin
                    if (pin_s_i) state_d = ST_START;
                end
                ST_START: begin
                    if (stc_q == STC_LAST) begin
                        state_d   = ST_IDLE;
                        release_w = 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stc_q   <= '0;
            pend_q  <= CAUSE_NONE;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            if (state_q == ST_START) stc_q <= stc_q + 1'b1;
            else                     stc_q <= '0;
            if (release_w)           cause_q <= pend_q;
        end
    end

    // outputs
    always_comb begin
        core_hold_o  = (state_q != ST_IDLE);
        brown_hold_o = (state_q == ST_BROWN);
        cause_o      = cause_q;
    end

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int LEN_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int START_CYC   = 3
) (
    input  logic               clk_slow,
    input  logic               rst_n,
    input  logic               pin_n_i,
    input  logic               bod_i,
    input  logic [LEN_W-1:0]   ext_len_i,
    output logic               proc_rst_n_o,
    output logic               periph_rst_n_o,
    output logic               pin_drive_n_o,
    output logic [CAUSE_W-1:0] cause_o
);

    logic bod_s, pin_s, own_echo;
    logic tmr_load, tmr_clear, tmr_active, tmr_last;
    logic core_hold, brown_hold, drive_w;

    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bod_sync (
        .clk(clk_slow), .rst_n(rst_n), .d_i(bod_i), .q_o(bod_s)
    );

    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk_slow), .rst_n(rst_n), .d_i(pin_n_i), .q_o(pin_s)
    );

    // delays the own drive by the pin synchronizer depth so a self-caused low is masked
    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_echo (
        .clk(clk_slow), .rst_n(rst_n), .d_i(drive_w), .q_o(own_echo)
    );

    rstseq_len_timer #(.LEN_W(LEN_W)) u_timer (
        .clk(clk_slow), .rst_n(rst_n),
        .clear_i(tmr_clear), .load_i(tmr_load), .len_i(ext_len_i),
        .active_o(tmr_active), .last_o(tmr_last)
    );

    rstseq_fsm #(.START_CYC(START_CYC)) u_fsm (
        .clk(clk_slow), .rst_n(rst_n),
        .bod_s_i(bod_s), .pin_s_i(pin_s), .own_echo_i(own_echo),
        .tmr_last_i(tmr_last), .tmr_load_o(tmr_load), .tmr_clear_o(tmr_clear),
        .core_hold_o(core_hold), .brown_hold_o(brown_hold), .cause_o(cause_o)
    );

    assign drive_w        = tmr_active | brown_hold;
    assign pin_drive_n_o  = ~drive_w;
    assign proc_rst_n_o   = ~core_hold;
    assign periph_rst_n_o = ~core_hold;

endmodule

// File: rtl/rstseq_ctrl_chk.sv
module rstseq_ctrl_chk
    import rstseq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bod_i,
    input logic               proc_n,
    input logic               periph_n,
    input logic               drive_n,
    input logic [CAUSE_W-1:0] cause
);

    AST_BROWN_ASSERTS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bod_i && $past(bod_i) && $past(bod_i, 2)) |=> (!proc_n && !periph_n && !drive_n)); // R6

    AST_CAUSE_ON_RELEASE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(proc_n) |-> $stable(cause)); // R9

    AST_CAUSE_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proc_n) |-> (cause == CAUSE_USER || cause == CAUSE_BROWN)); // R9

    AST_STARTUP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proc_n) |-> (!$past(proc_n) && !$past(proc_n, 2) && !$past(proc_n, 3))); // R5

    AST_DRIVE_NOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_n) |=> !drive_n); // R3

    AST_PERIPH_WITH_PROC: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(proc_n) |-> $rose(periph_n)) and ($fell(proc_n) |-> $fell(periph_n))); // R11

endmodule

bind rstseq_ctrl rstseq_ctrl_chk u_chk (
    .clk(clk_slow), .rst_n(rst_n), .bod_i(bod_i),
    .proc_n(proc_rst_n_o), .periph_n(periph_rst_n_o),
    .drive_n(pin_drive_n_o), .cause(cause_o)
);

// File: tb/rstseq_ctrl_tb_top.sv
module rstseq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_hold = 1'b0;
    logic       bod = 1'b0;
    logic [3:0] ext_len = 4'd0;
    logic       proc_n, periph_n, drive_n;
    logic [2:0] cause;
    logic       pin_n;

    int n_tests = 0;
    int n_fail  = 0;
    int prev_cause = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // open-drain pin: low if the outside holder or the block pulls it
    assign pin_n = ~ext_hold & drive_n;

    rstseq_ctrl dut_i (
        .clk_slow(clk), .rst_n(rst_n), .pin_n_i(pin_n), .bod_i(bod),
        .ext_len_i(ext_len), .proc_rst_n_o(proc_n), .periph_rst_n_o(periph_n),
        .pin_drive_n_o(drive_n), .cause_o(cause)
    );

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int pulse_len(int len);
        return 1 << (len + 1);
    endfunction

    // kind 0 user, 1 brownout, 2 brownout during user
    task automatic run_case(int kind, int len, int h, int j, int d);
        int n = pulse_len(len);
        int win = h + j + d + 2 * n + 30;
        int plow = 0, dlow = 0, mism = 0, relow = 0;
        int first = -1, last = -1;
        bit released = 1'b0;
        int e_plow, e_dlow, e_cause;
        ext_len = 4'(len);
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (proc_n !== periph_n) mism++;
            if (!proc_n) begin
                if (released) relow++;
                else begin
                    plow++;
                    if (first < 0) begin
                        first = i;
                        check("R9 cause held until release", int'(cause), prev_cause);
                    end
                    last = i;
                end
            end else if (first >= 0) released = 1'b1;
            if (!drive_n) dlow++;
            ext_hold = (kind != 1) && (i < h);
            bod = (kind == 1) ? (i < d) : ((kind == 2) && (i >= j) && (i < j + d));
        end
        if (kind == 0) begin
            e_plow = max2(n + 6, h + 3); e_dlow = n; e_cause = 4;
        end else if (kind == 1) begin
            e_plow = d + 3; e_dlow = d + n; e_cause = 5;
        end else begin
            e_plow = j + d + 3; e_dlow = j + d + n; e_cause = 5;
        end
        // first sample index 0 precedes edge k; low after edge k+2 shows at sample 3
        check((kind == 1) ? "R6 brownout entry latency" : "R2 user entry latency", first, 3);
        check((kind == 0) ? "R4 proc low length" : ((kind == 1) ? "R7 proc low length" : "R10 proc low length"), plow, e_plow);
        check((kind == 0) ? "R3 pin drive length" : "R8 pin drive length", dlow, e_dlow);
        check((kind == 2) ? "R10 cause after abort" : "R9 cause after release", int'(cause), e_cause);
        check("R11 periph follows proc", mism, 0);
        check("R12 no self-triggered reset", relow, 0);
        if (kind == 1) check("R5 startup after brownout end", last, d + 5);
        if (kind == 0 && h + 3 > n + 6) check("R5 startup after pin release", last, h + 5);
        prev_cause = int'(cause);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 proc reset idle", int'(proc_n), 1);
        check("R1 periph reset idle", int'(periph_n), 1);
        check("R1 pin drive idle", int'(drive_n), 1);
        check("R1 cause cleared", int'(cause), 0);

        void'($urandom(32'h5eed_1234));
        run_case(0, 0, 1, 0, 0);      // shortest pulse
        run_case(0, 1, 20, 0, 0);     // outside holder extends
        run_case(1, 2, 0, 0, 5);      // brownout with long pulse
        run_case(1, 0, 0, 0, 1);      // one-cycle brownout
        run_case(2, 2, 1, 3, 4);      // brownout aborts user
        run_case(2, 1, 2, 4, 2);      // brownout on last pulse cycle
        for (int it = 0; it < 24; it++) begin
            int kind = $urandom_range(0, 2);
            int len  = $urandom_range(0, 3);
            int n    = pulse_len(len);
            if (kind == 0) run_case(0, len, $urandom_range(1, n + 10), 0, 0);
            else if (kind == 1) run_case(1, len, 0, 0, $urandom_range(1, 12));
            else begin
                int j = $urandom_range(1, n);
                run_case(2, len, $urandom_range(1, j), j, $urandom_range(1, 8));
            end
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule